// File: doc/BRIEF.md
# Host Wake/Sleep Handshake Controller

This block decides, together with the host processor, when a radio controller may stop its system clock and when it must have it back. It watches the host's wake signalling, the UART receive line and the host's clear-to-send line. It drives a wake line back to the host, its own request-to-send line, a sleep-enable to the local clock gating, and an awake status. The UART datapath, the clock source and the power switches sit outside it.

Two strap pins choose one of two handshakes. In the break variant, the host grants sleep by holding the UART receive line low for longer than one character. In the wake-line variant, the host grants sleep through a dedicated wake line and confirms with clear-to-send. In both variants the device lifts request-to-send before it lowers its wake line. Wake-up can start from either side. Request-to-send only falls once the local clock reports ready. The two remaining strap codes are reserved, and in them the device stays awake.

Top module: `host_wake_ctl`

## Requirements
- R1: Out of reset the outputs read awake=1, sleep_en=0, rts=0, dev_wake=1.
- R2: Strap code {sel_a,sel_b}=01 selects the break variant and 10 selects the wake-line variant. Codes 00 and 11 are reserved: the block stays awake with rts low and dev_wake high whatever the other inputs do.
- R3: In the break variant, host permission exists once the synchronized host_rx has been low for 10*bit_period consecutive clock cycles. A shorter low pulse has no effect. Host inputs pass through two synchronizer flops, so rts rises on the (10*bit_period+3)th clock edge after host_rx falls.
- R4: Sleep entry raises rts one cycle before dev_wake falls. In the break variant, sleep_en rises on the following cycle.
- R5: In the wake-line variant, host_wake_in low grants permission. After dev_wake falls, sleep_en rises only once the synchronized host_cts is high.
- R6: With can_sleep low, or with need_wake high, the block declines permission and stays awake.
- R7: Device-initiated wake: need_wake during sleep raises dev_wake and clears sleep_en on the next cycle. rts falls only on the cycle after clk_ready is seen high. awake returns once the host acknowledges: host_rx high in the break variant, or host_wake_in high with host_cts low in the wake-line variant.
- R8: Host-initiated wake: host_rx high (break variant) or host_wake_in high (wake-line variant) during sleep raises dev_wake and clears sleep_en. rts then falls after clk_ready, and awake returns under the same acknowledge rule as R7.
- R9: A host wake request or need_wake that arrives during entry, before sleep_en rises, aborts the entry. The block returns to awake with rts low and dev_wake high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_a | input | 1 | Handshake strap, high bit |
| sel_b | input | 1 | Handshake strap, low bit |
| bit_period | input | BP_W | UART bit time in clock cycles |
| host_rx | input | 1 | UART receive line from host (asynchronous) |
| host_wake_in | input | 1 | Host-to-device wake line (asynchronous) |
| host_cts | input | 1 | Clear-to-send from host (asynchronous) |
| can_sleep | input | 1 | Local scheduler allows sleep |
| need_wake | input | 1 | Local activity needs the clock |
| clk_ready | input | 1 | Local clock is running and stable |
| dev_wake | output | 1 | Device-to-host wake line |
| rts | output | 1 | Request-to-send to host (high blocks traffic) |
| sleep_en | output | 1 | Enable for local clock gating |
| awake | output | 1 | Block is in the fully awake state |

## Verification
The bench times the break threshold exactly. It checks that rts is still low one cycle before the expected edge and high on that edge, and that a pulse a few cycles short is ignored. An off-by-one counter or a missing synchronizer stage would move that edge. Aborts are forced both while rts is up and while the device waits for clear-to-send. A design that ignored them would sleep after the host had asked for the link back. Random trials vary the bit period, the wake initiator and the clock-ready delay. Dropping rts before clk_ready, or returning awake before the host acknowledges, shows up as an output mismatch at a fixed cycle.

// File: rtl/host_wake_ctl.sv
module host_wake_ctl #(
  parameter int BP_W      = 16,
  parameter int CHAR_BITS = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_a,
  input  logic            sel_b,
  input  logic [BP_W-1:0] bit_period,
  input  logic            host_rx,
  input  logic            host_wake_in,
  input  logic            host_cts,
  input  logic            can_sleep,
  input  logic            need_wake,
  input  logic            clk_ready,
  output logic            dev_wake,
  output logic            rts,
  output logic            sleep_en,
  output logic            awake
);

  localparam int CNT_W = BP_W + $clog2(CHAR_BITS) + 1;

  typedef enum logic [2:0] {
    ST_AWAKE, ST_RTS, ST_LOW, ST_SLEEP, ST_CLK, ST_ACK
  } st_t;

  st_t st, st_nx;

  logic [2:0] s1, s2;
  logic rx_s, wk_s, cts_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 3'b110;
      s2 <= 3'b110;
    end else begin
      s1 <= {host_rx, host_wake_in, host_cts};
      s2 <= s1;
    end

  assign {rx_s, wk_s, cts_s} = s2;

  wire v1 = !sel_a && sel_b;
  wire v2 = sel_a && !sel_b;

  logic [CNT_W-1:0] brk_cnt;
  wire  [CNT_W-1:0] thr = CNT_W'(bit_period) * CNT_W'(CHAR_BITS);
  wire              brk = (thr != '0) && (brk_cnt >= thr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              brk_cnt <= '0;
    else if (rx_s)           brk_cnt <= '0;
    else if (brk_cnt < thr)  brk_cnt <= brk_cnt + 1'b1;

  wire host_req = v1 ? rx_s : wk_s;
  wire permit   = v1 ? brk : (v2 && !wk_s);
  wire host_ack = v1 ? rx_s : (wk_s && !cts_s);

  always_comb begin
    st_nx = st;
    case (st)
      ST_AWAKE: if (permit && can_sleep && !need_wake) st_nx = ST_RTS;
      ST_RTS:   st_nx = (host_req || need_wake) ? ST_AWAKE : ST_LOW;
      ST_LOW:   if (host_req || need_wake) st_nx = ST_AWAKE;
                else if (v1 || cts_s)      st_nx = ST_SLEEP;
      ST_SLEEP: if (host_req || need_wake) st_nx = ST_CLK;
      ST_CLK:   if (clk_ready) st_nx = ST_ACK;
      ST_ACK:   if (host_ack)  st_nx = ST_AWAKE;
      default:  st_nx = ST_AWAKE;
    endcase
    if (!(v1 || v2)) st_nx = ST_AWAKE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= ST_AWAKE;
    else        st <= st_nx;

  assign rts      = (st == ST_RTS) || (st == ST_LOW) || (st == ST_SLEEP) || (st == ST_CLK);
  assign dev_wake = !((st == ST_LOW) || (st == ST_SLEEP));
  assign sleep_en = (st == ST_SLEEP);
  assign awake    = (st == ST_AWAKE);

  // R2
  rsv_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(v1 || v2) |-> awake && !rts && dev_wake);

  // R4
  rts_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_wake) |-> rts && $past(rts));

  // R4
  sleep_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_en |-> rts && !dev_wake);

  // R5
  sleep_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_en) |-> !$past(host_req) && (v1 || $past(cts_s)));

  // R6
  decline_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts) |-> $past(can_sleep) && !$past(need_wake));

  // R7
  clk_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rts) && !awake) |-> $past(clk_ready) && dev_wake);

endmodule

// File: tb/host_wake_ctl_tb.sv
module host_wake_ctl_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic sel_a, sel_b;
  logic [15:0] bit_period;
  logic host_rx, host_wake_in, host_cts, can_sleep, need_wake, clk_ready;
  logic dev_wake, rts, sleep_en, awake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  host_wake_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b),
    .bit_period(bit_period), .host_rx(host_rx), .host_wake_in(host_wake_in),
    .host_cts(host_cts), .can_sleep(can_sleep), .need_wake(need_wake),
    .clk_ready(clk_ready), .dev_wake(dev_wake), .rts(rts),
    .sleep_en(sleep_en), .awake(awake)
  );

  localparam int PH_AWAKE = 0, PH_RTS = 1, PH_LOW = 2, PH_SLEEP = 3, PH_CLK = 4, PH_ACK = 5;

  // {awake, sleep_en, rts, dev_wake}
  function automatic logic [3:0] exp_out(int ph);
    case (ph)
      PH_AWAKE: return 4'b1001;
      PH_RTS:   return 4'b0011;
      PH_LOW:   return 4'b0010;
      PH_SLEEP: return 4'b0110;
      PH_CLK:   return 4'b0011;
      default:  return 4'b0001;
    endcase
  endfunction

  function automatic int break_cycles(int bp);
    return bp * 10;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int ph);
    logic [3:0] act;
    act = {awake, sleep_en, rts, dev_wake};
    checks++;
    if (act !== exp_out(ph)) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp_out(ph));
    end
  endtask

  task automatic do_reset(logic a, logic b, int bp);
    rst_n = 1'b0;
    sel_a = a; sel_b = b; bit_period = 16'(bp);
    host_rx = 1'b1; host_wake_in = 1'b1; host_cts = 1'b0;
    can_sleep = 1'b0; need_wake = 1'b0; clk_ready = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic enter_v1(int bp);
    can_sleep = 1'b1;
    host_rx = 1'b0;
    tick(break_cycles(bp) + 2); check("R3", PH_AWAKE);
    tick(1); check("R3", PH_RTS);
    tick(1); check("R4", PH_LOW);
    tick(1); check("R4", PH_SLEEP);
  endtask

  task automatic enter_v2();
    can_sleep = 1'b1;
    host_wake_in = 1'b0;
    tick(2); check("R5", PH_AWAKE);
    tick(1); check("R4", PH_RTS);
    tick(1); check("R4", PH_LOW);
    tick(3); check("R5", PH_LOW);
    host_cts = 1'b1;
    tick(2); check("R5", PH_LOW);
    tick(1); check("R5", PH_SLEEP);
  endtask

  task automatic wake(bit brk_mode, bit host_init, int dly);
    string tag;
    tag = host_init ? "R8" : "R7";
    if (host_init) begin
      if (brk_mode) host_rx = 1'b1; else host_wake_in = 1'b1;
      tick(2); check(tag, PH_SLEEP);
      tick(1); check(tag, PH_CLK);
    end else begin
      need_wake = 1'b1;
      tick(1); check(tag, PH_CLK);
    end
    for (int i = 0; i < dly; i++) begin
      tick(1); check(tag, PH_CLK);
    end
    clk_ready = 1'b1;
    tick(1); check(tag, PH_ACK);
    if (brk_mode && host_init) begin
      tick(1); check(tag, PH_AWAKE);
    end else begin
      if (brk_mode) host_rx = 1'b1;
      else begin host_wake_in = 1'b1; host_cts = 1'b0; end
      tick(2); check(tag, PH_ACK);
      tick(1); check(tag, PH_AWAKE);
    end
    need_wake = 1'b0; clk_ready = 1'b0; can_sleep = 1'b0;
    tick(1);
  endtask

  initial begin
    void'($urandom(32'h5EED1));

    do_reset(1'b0, 1'b1, 3);
    check("R1", PH_AWAKE);

    can_sleep = 1'b1;
    host_rx = 1'b0;
    tick(break_cycles(3) - 4);
    host_rx = 1'b1;
    tick(40); check("R3", PH_AWAKE);

    do_reset(1'b0, 1'b1, 3);
    enter_v1(3);
    wake(1'b1, 1'b0, 2);
    do_reset(1'b0, 1'b1, 2);
    enter_v1(2);
    wake(1'b1, 1'b1, 0);

    do_reset(1'b1, 1'b0, 4);
    enter_v2();
    wake(1'b0, 1'b0, 3);
    do_reset(1'b1, 1'b0, 4);
    enter_v2();
    wake(1'b0, 1'b1, 1);

    do_reset(1'b1, 1'b0, 4);
    host_wake_in = 1'b0;
    tick(10); check("R6", PH_AWAKE);
    can_sleep = 1'b1; need_wake = 1'b1;
    tick(10); check("R6", PH_AWAKE);

    do_reset(1'b1, 1'b0, 4);
    can_sleep = 1'b1; host_wake_in = 1'b0;
    tick(3); check("R9", PH_RTS);
    need_wake = 1'b1;
    tick(1); check("R9", PH_AWAKE);

    do_reset(1'b1, 1'b0, 4);
    can_sleep = 1'b1; host_wake_in = 1'b0;
    tick(4); check("R9", PH_LOW);
    host_wake_in = 1'b1;
    tick(2); check("R9", PH_LOW);
    tick(1); check("R9", PH_AWAKE);

    for (int m = 0; m < 2; m++) begin
      do_reset(m[0], m[0], 1);
      can_sleep = 1'b1; host_rx = 1'b0; host_wake_in = 1'b0; host_cts = 1'b1;
      tick(60); check("R2", PH_AWAKE);
    end

    for (int it = 0; it < 24; it++) begin
      bit brk_mode;
      bit hinit;
      int bp;
      int dly;
      brk_mode = 1'($urandom % 2);
      hinit    = 1'($urandom % 2);
      bp       = 1 + int'($urandom % 6);
      dly      = int'($urandom % 6);
      do_reset(!brk_mode, brk_mode, bp);
      if (brk_mode) enter_v1(bp); else enter_v2();
      wake(brk_mode, hinit, dly);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule